// File: doc/BRIEF.md
# Syscall Event Drain Controller

This block sequences the pipeline around a syscall-event instruction in a processor that runs each software thread on its own hardware thread (hart) and keeps the scheduling decision in a hardware scheduler FSM. When the execute stage holds such an instruction, the controller stalls the front of the pipeline and waits for the memory and commit stages to empty. Because everything older than the syscall has then retired, any exception raised by those older instructions stays precise.

Once the pipeline is empty, the controller hands the instruction's event code to the scheduler FSM with a one-cycle strobe. It keeps the stall in place until the FSM reports that the transition is done. If the FSM keeps the same hart, the stall is released and the instruction stream continues with no flush. If the FSM switches harts, the controller first stores the caller's resume address in that hart's PC slot. It then issues a single flush cycle on the mispredict path, which redirects fetch to the PC stored for the new hart. Boot code fills the PC slots through a load port.

Top module: `sysev_drain_ctrl`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, stall, flush, redir_vld and ev_stb are 0 and cur_hart is 0.
- R2: stall is 1 in the same cycle that an idle controller sees ex_sysev=1. It stays 1 through the drain, the event transfer and the wait for the FSM.
- R3: ev_stb is a single-cycle pulse. It comes exactly one cycle after the first drain cycle in which mem_vld and com_vld are both 0. Counting the cycle in which the syscall is first seen as cycle 0, with the pipeline busy through cycle k, the pulse is in cycle k+2. With an empty pipeline it is in cycle 2.
- R4: While ev_stb is 1, ev_code equals the ex_code value captured when the syscall was first seen.
- R5: When fsm_rdy=1 with fsm_resched=0 during the wait, stall drops in the next cycle and no flush is issued.
- R6: When fsm_rdy=1 with fsm_resched=1 during the wait, the next cycle has flush=1 and redir_vld=1 for exactly one cycle, with stall=0. In that cycle redir_hart equals the fsm_hart value that was given.
- R7: On a reschedule, the ex_npc value captured with the syscall is written to the PC slot of the hart that was running. A later switch back to that hart redirects to that value.
- R8: cur_hart takes the new fsm_hart value in the flush cycle and keeps it until the next reschedule.
- R9: pc_ld=1 writes pc_ld_val into slot pc_ld_hart. If the same slot is being saved by a reschedule in that cycle, the save wins. redir_pc in a flush cycle is the slot of the new hart.
- R10: fsm_rdy and fsm_resched have no effect outside the wait for the FSM: no flush, and cur_hart does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ex_sysev | input | 1 | Execute stage holds a syscall-event instruction |
| ex_code | input | EVW | Event code carried by that instruction |
| ex_npc | input | PCW | Address of the instruction after the syscall |
| mem_vld | input | 1 | Memory stage holds a valid instruction |
| com_vld | input | 1 | Commit stage holds a valid instruction |
| fsm_rdy | input | 1 | Scheduler FSM has applied its transition |
| fsm_resched | input | 1 | With fsm_rdy, the FSM selects a different hart |
| fsm_hart | input | $clog2(NHART) | Hart chosen by the FSM |
| pc_ld | input | 1 | Write a PC slot (boot-time setup) |
| pc_ld_hart | input | $clog2(NHART) | Slot to write |
| pc_ld_val | input | PCW | Value to write |
| stall | output | 1 | Hold the stages in front of execute |
| flush | output | 1 | Flush through the mispredict path |
| redir_vld | output | 1 | Fetch redirect valid |
| redir_pc | output | PCW | Fetch redirect address |
| redir_hart | output | $clog2(NHART) | Hart tag for the redirected fetch |
| ev_stb | output | 1 | Event code valid towards the FSM |
| ev_code | output | EVW | Event code towards the FSM |
| cur_hart | output | $clog2(NHART) | Hart currently running |

## Verification
A controller stuck in the wrong state shows up as a stall level that disagrees with the model within one cycle. Examples are an event strobe sent while the memory or commit stage is still busy, and a missing or doubled flush. A corrupt PC slot stays hidden until a later reschedule selects that hart, so the bench switches back to earlier harts and compares redir_pc at that point. A wrong hart register shows at cur_hart in the flush cycle itself.

// File: rtl/sysev_drain_ctrl.sv
module sysev_drain_ctrl #(
  parameter int NHART = 4,
  parameter int PCW   = 32,
  parameter int EVW   = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ex_sysev,
  input  logic [EVW-1:0]           ex_code,
  input  logic [PCW-1:0]           ex_npc,
  input  logic                     mem_vld,
  input  logic                     com_vld,
  input  logic                     fsm_rdy,
  input  logic                     fsm_resched,
  input  logic [$clog2(NHART)-1:0] fsm_hart,
  input  logic                     pc_ld,
  input  logic [$clog2(NHART)-1:0] pc_ld_hart,
  input  logic [PCW-1:0]           pc_ld_val,
  output logic                     stall,
  output logic                     flush,
  output logic                     redir_vld,
  output logic [PCW-1:0]           redir_pc,
  output logic [$clog2(NHART)-1:0] redir_hart,
  output logic                     ev_stb,
  output logic [EVW-1:0]           ev_code,
  output logic [$clog2(NHART)-1:0] cur_hart
);
  localparam int HW = $clog2(NHART);

  typedef enum logic [2:0] {S_IDLE, S_DRAIN, S_SEND, S_WAIT, S_FLUSH} st_t;

  st_t            st_q, st_d;
  logic [EVW-1:0] code_q;
  logic [PCW-1:0] npc_q;
  logic [HW-1:0]  hart_q;
  logic [PCW-1:0] slot_q [NHART];

  logic take, drained, switch_hart;
  assign take        = (st_q == S_IDLE) && ex_sysev;
  assign drained     = !mem_vld && !com_vld;
  assign switch_hart = (st_q == S_WAIT) && fsm_rdy && fsm_resched;

  always_comb begin
    st_d = st_q;
    case (st_q)
      S_IDLE:  if (ex_sysev) st_d = S_DRAIN;
      S_DRAIN: if (drained) st_d = S_SEND;
      S_SEND:  st_d = S_WAIT;
      S_WAIT:  if (fsm_rdy) st_d = fsm_resched ? S_FLUSH : S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      code_q <= '0;
      npc_q  <= '0;
      hart_q <= '0;
    end else begin
      st_q <= st_d;
      if (take) begin
        code_q <= ex_code;
        npc_q  <= ex_npc;
      end
      if (switch_hart) hart_q <= fsm_hart;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NHART; i++) slot_q[i] <= '0;
    end else begin
      for (int i = 0; i < NHART; i++) begin
        if (switch_hart && hart_q == HW'(i))
          slot_q[i] <= npc_q;
        else if (pc_ld && pc_ld_hart == HW'(i))
          slot_q[i] <= pc_ld_val;
      end
    end
  end

  assign stall      = take || (st_q == S_DRAIN) || (st_q == S_SEND) || (st_q == S_WAIT);
  assign flush      = (st_q == S_FLUSH);
  assign redir_vld  = flush;
  assign redir_pc   = slot_q[hart_q];
  assign redir_hart = hart_q;
  assign ev_stb     = (st_q == S_SEND);
  assign ev_code    = code_q;
  assign cur_hart   = hart_q;
endmodule

// File: rtl/sysev_drain_chk.sv
module sysev_drain_chk #(
  parameter int NHART = 4,
  parameter int PCW   = 32,
  parameter int EVW   = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     mem_vld,
  input logic                     com_vld,
  input logic                     fsm_rdy,
  input logic                     fsm_resched,
  input logic [$clog2(NHART)-1:0] fsm_hart,
  input logic                     stall,
  input logic                     flush,
  input logic                     redir_vld,
  input logic [$clog2(NHART)-1:0] redir_hart,
  input logic                     ev_stb,
  input logic [$clog2(NHART)-1:0] cur_hart
);
  // R3
  send_after_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stb |-> $past(!mem_vld && !com_vld));
  // R3
  send_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stb |=> !ev_stb);
  // R2
  send_stalled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stb |-> stall);
  // R6
  flush_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !flush);
  // R6
  flush_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> (redir_vld && !stall && redir_hart == cur_hart));
  // R8
  flush_hart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> ($past(fsm_rdy && fsm_resched) && cur_hart == $past(fsm_hart)));
  // R10
  hart_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !flush |-> $stable(cur_hart));
endmodule

bind sysev_drain_ctrl sysev_drain_chk #(.NHART(NHART), .PCW(PCW), .EVW(EVW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_vld(mem_vld), .com_vld(com_vld),
  .fsm_rdy(fsm_rdy), .fsm_resched(fsm_resched), .fsm_hart(fsm_hart),
  .stall(stall), .flush(flush), .redir_vld(redir_vld), .redir_hart(redir_hart),
  .ev_stb(ev_stb), .cur_hart(cur_hart)
);

// File: tb/sysev_drain_ctrl_tb.sv
module sysev_drain_ctrl_tb;
  logic clk = 0;
  always #5 clk = ~clk;

  logic        rst_n = 0;
  logic        ex_sysev = 0;
  logic [7:0]  ex_code = 0;
  logic [31:0] ex_npc = 0;
  logic        mem_vld = 0, com_vld = 0, fsm_rdy = 0, fsm_resched = 0;
  logic [1:0]  fsm_hart = 0;
  logic        pc_ld = 0;
  logic [1:0]  pc_ld_hart = 0;
  logic [31:0] pc_ld_val = 0;
  logic        stall, flush, redir_vld, ev_stb;
  logic [31:0] redir_pc;
  logic [1:0]  redir_hart, cur_hart;
  logic [7:0]  ev_code;

  sysev_drain_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .ex_sysev(ex_sysev), .ex_code(ex_code), .ex_npc(ex_npc),
    .mem_vld(mem_vld), .com_vld(com_vld), .fsm_rdy(fsm_rdy), .fsm_resched(fsm_resched),
    .fsm_hart(fsm_hart), .pc_ld(pc_ld), .pc_ld_hart(pc_ld_hart), .pc_ld_val(pc_ld_val),
    .stall(stall), .flush(flush), .redir_vld(redir_vld), .redir_pc(redir_pc),
    .redir_hart(redir_hart), .ev_stb(ev_stb), .ev_code(ev_code), .cur_hart(cur_hart)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Reference model: phase 0 idle, 1 waiting for empty pipe, 2 handing over, 3 waiting for FSM, 4 redirect
  int          m_ph;
  logic [7:0]  m_code;
  logic [31:0] m_npc;
  logic [1:0]  m_cur;
  logic [31:0] m_slot [4];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_code = 0; m_npc = 0; m_cur = 0;
      for (int i = 0; i < 4; i++) m_slot[i] = 0;
    end else begin
      if (pc_ld) m_slot[pc_ld_hart] = pc_ld_val;
      case (m_ph)
        0: if (ex_sysev) begin m_code = ex_code; m_npc = ex_npc; m_ph = 1; end
        1: if (!mem_vld && !com_vld) m_ph = 2;
        2: m_ph = 3;
        3: if (fsm_rdy) begin
             if (fsm_resched) begin
               m_slot[m_cur] = m_npc;
               m_cur = fsm_hart;
               m_ph = 4;
             end else m_ph = 0;
           end
        default: m_ph = 0;
      endcase
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R2 stall", stall, (m_ph == 0 && ex_sysev) || m_ph == 1 || m_ph == 2 || m_ph == 3);
      chk("R3 ev_stb", ev_stb, m_ph == 2);
      if (m_ph == 2) chk("R4 ev_code", ev_code, m_code);
      chk("R6 flush", flush, m_ph == 4);
      chk("R6 redir_vld", redir_vld, m_ph == 4);
      if (m_ph == 4) begin
        chk("R7 redir_pc", redir_pc, m_slot[m_cur]);
        chk("R6 redir_hart", redir_hart, m_cur);
      end
      chk("R8 cur_hart", cur_hart, m_cur);
    end
  end

  task automatic cyc();
    @(posedge clk); #2;
  endtask

  task automatic do_call(logic [7:0] code, logic [31:0] npc, int busy, int waitc,
                         bit resched, logic [1:0] nh, logic [31:0] exp_pc);
    int c = 0;
    ex_sysev = 1; ex_code = code; ex_npc = npc;
    forever begin
      mem_vld = (busy > 0) && (c <= busy);
      com_vld = mem_vld;
      @(negedge clk);
      if (ev_stb) break;
      if (c > 50) break;
      cyc(); c++;
    end
    chk("R3 strobe cycle", c, busy + 2);
    chk("R4 code", ev_code, code);
    cyc();
    repeat (waitc) cyc();
    fsm_rdy = 1; fsm_resched = resched; fsm_hart = nh;
    @(negedge clk);
    chk("R5 stall while waiting", stall, 1);
    cyc();
    fsm_rdy = 0; fsm_resched = 0; ex_sysev = 0;
    @(negedge clk);
    if (resched) begin
      chk("R6 flush", flush, 1);
      chk("R7 redirect pc", redir_pc, exp_pc);
      chk("R8 hart", cur_hart, nh);
    end else begin
      chk("R5 stall released", stall, 0);
      chk("R5 no flush", flush, 0);
    end
    cyc();
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 stall", stall, 0);
    chk("R1 flush", flush, 0);
    chk("R1 ev_stb", ev_stb, 0);
    chk("R1 redir_vld", redir_vld, 0);
    chk("R1 cur_hart", cur_hart, 0);
    cyc();
    rst_n = 1;
    @(negedge clk);
    chk("R1 after reset", {stall, flush, ev_stb}, 0);
    cyc();
    for (int i = 0; i < 4; i++) begin
      pc_ld = 1; pc_ld_hart = 2'(i); pc_ld_val = 32'h1000 * (i + 1);
      cyc();
    end
    pc_ld = 0;
    do_call(8'h11, 32'h0104, 3, 0, 0, 2'd0, 0);
    do_call(8'h22, 32'h0208, 0, 2, 1, 2'd2, 32'h3000);
    do_call(8'h33, 32'h3010, 1, 0, 1, 2'd0, 32'h0208);
    // R10: stray FSM handshake while idle
    fsm_rdy = 1; fsm_resched = 1; fsm_hart = 2'd3;
    cyc();
    fsm_rdy = 0; fsm_resched = 0;
    @(negedge clk);
    chk("R10 no flush", flush, 0);
    chk("R10 hart kept", cur_hart, 0);
    cyc();
    // R9: load a slot then switch to it
    pc_ld = 1; pc_ld_hart = 2'd3; pc_ld_val = 32'hABC0;
    cyc();
    pc_ld = 0;
    do_call(8'h44, 32'h0300, 2, 4, 1, 2'd3, 32'hABC0);
    do_call(8'h55, 32'hAC00, 0, 1, 1, 2'd2, 32'h3010);
    for (int n = 0; n < 4000; n++) begin
      ex_sysev    = ($urandom_range(0, 9) < 3);
      ex_code     = 8'($urandom);
      ex_npc      = $urandom;
      mem_vld     = $urandom_range(0, 1);
      com_vld     = $urandom_range(0, 1);
      fsm_rdy     = ($urandom_range(0, 9) < 4);
      fsm_resched = $urandom_range(0, 1);
      fsm_hart    = 2'($urandom);
      pc_ld       = ($urandom_range(0, 9) < 1);
      pc_ld_hart  = 2'($urandom);
      pc_ld_val   = $urandom;
      cyc();
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule